// File: doc/BRIEF.md
# Prescaled Reload Timer with Interrupt Request

This block is a down-counting timer peripheral reached through a small byte-wide register bus. Software loads the count one byte at a time, picks a prescaler divide through a mode register, sets a run bit and programs an interrupt-control byte that holds a 3-bit level and a request flag. While running, every `tick` strobe moves a prescaler. Each time the prescaler wraps, the main count steps down by one. When the count steps below zero it is refilled from a reload register, and the request flag is latched if the level is nonzero.

The block also compares the programmed level with the CPU's current priority. It raises `irq_pending` while the CPU has interrupts enabled, the request flag is set and the level outranks the CPU priority. Software acknowledges a request by writing the control byte with the flag cleared. Reads return the live count and the stored registers.

Top module: `prt_timer`

## Requirements
- R1: Writing count byte k (offset k, where offset 0 is bits 7:0 and offset 1 is bits 15:8) replaces that byte of the count, and the whole resulting count is copied into the reload register.
- R2: The run register lives at offset 2, and its bit 0 enables counting. While that bit is 0, `tick` changes neither the prescaler nor the count.
- R3: When running, each `tick` decrements the prescaler. A `tick` that finds the prescaler at 0 instead reloads the prescaler and steps the count once. With a prescaler reload of N, the count therefore steps once every N+1 ticks.
- R4: The prescaler reload value comes from bits 7:6 of the mode register at offset 3: 00 gives 0, 01 gives 8, 10 gives bits 3:0 of the divider register at offset 4, and 11 gives 32.
- R5: A count step that finds the count at 0 loads the count from the reload register. This event is the underflow.
- R6: The interrupt-control byte is at offset 5, with the level in bits 2:0 and the request flag in bit 3. On underflow the request flag is set if the level is nonzero, and is left unchanged if the level is 0.
- R7: `irq_pending` is 1 exactly when `cpu_ie` is 1, the request flag is 1, and the level is strictly greater than `cpu_prio`.
- R8: Reads return the live count bytes at offsets 0 and 1, and the stored run, mode, divider and interrupt-control bytes at offsets 2 to 5. Offsets 6 and 7 read as 0, and writes to them have no effect.
- R9: Software can read and write all 8 bits of the interrupt-control byte. A write to it in the same cycle as an underflow wins, so the written value is kept.
- R10: A count-byte write in the same cycle as a count step wins. The written value is loaded, and that cycle's step and any underflow request are dropped. The prescaler still moves.
- R11: Synchronous reset clears the count, reload, prescaler, run, mode, divider and interrupt-control registers, so every offset reads 0 and `irq_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 3 | Register offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data at `bus_addr` |
| tick | input | 1 | Single-cycle count enable strobe |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_prio | input | 3 | CPU current priority level |
| irq_pending | output | 1 | Interrupt request outranks the CPU priority |

## Verification
The bench checks the period of each prescaler mode, including divide-by-one and the divide taken from the low nibble of the divider register. A wrong mode decode would show up as a count that steps at the wrong rate. It runs the count through zero with both a zero and a nonzero level: a design that reloaded late, decremented past zero, or latched a request at level 0 would read back the wrong count or the wrong control byte. It checks `irq_pending` with the level equal to the CPU priority, one above it, and with interrupts disabled, which catches a comparison that is off by one. It also lines up a bus write with a count step or an underflow in the same cycle, which exposes the wrong winner of that collision.

// File: rtl/prt_pkg.sv
package prt_pkg;

    localparam int BYTE_W = 8;

    // Prescaler source select, decoded from mode bits 7:6
    typedef enum logic [1:0] {
        PS_NONE  = 2'b00,
        PS_FIX_A = 2'b01,
        PS_FIELD = 2'b10,
        PS_FIX_B = 2'b11
    } ps_sel_e;

    // Interrupt-control byte layout
    typedef struct packed {
        logic [3:0] spare;
        logic       req;
        logic [2:0] level;
    } ictl_t;

    // Reload value picked for the prescaler
    function automatic int unsigned ps_pick(ps_sel_e sel, logic [3:0] field,
                                            int unsigned fix_a, int unsigned fix_b);
        int unsigned v;
        case (sel)
            PS_NONE:  v = 0;
            PS_FIX_A: v = fix_a;
            PS_FIELD: v = int'(field);
            default:  v = fix_b;
        endcase
        return v;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/prt_regs.sv
module prt_regs
    import prt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_wr,
    input  logic              mode_wr,
    input  logic              div_wr,
    input  logic              ictl_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              req_set,
    output logic [BYTE_W-1:0] run_q,
    output logic [BYTE_W-1:0] mode_q,
    output logic [BYTE_W-1:0] div_q,
    output ictl_t             ictl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            mode_q <= '0;
            div_q  <= '0;
            ictl_q <= '0;
        end else begin
            if (run_wr)  run_q  <= wdata;
            if (mode_wr) mode_q <= wdata;
            if (div_wr)  div_q  <= wdata;
            if (ictl_wr)
                ictl_q <= ictl_t'(wdata);
            else if (req_set && (ictl_q.level != 3'd0))
                ictl_q.req <= 1'b1;
        end
    end

    // R6: underflow with nonzero level latches the request flag
    a_r6_req_latch: assert property (@(posedge clk) disable iff (rst)
        (req_set && !ictl_wr && (ictl_q.level != 3'd0)) |=> ictl_q.req);

    // R6: underflow at level zero leaves the byte untouched
    a_r6_level_zero: assert property (@(posedge clk) disable iff (rst)
        (!ictl_wr && (ictl_q.level == 3'd0)) |=> $stable(ictl_q));

    // R9: a software write wins over a same-cycle request
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        ictl_wr |=> (ictl_q == ictl_t'($past(wdata))));

endmodule

// File: rtl/prt_counter.sv
module prt_counter
    import prt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PS_W  = 6,
    localparam int NB   = CNT_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic [PS_W-1:0]   ps_reload,
    input  logic [NB-1:0]     byte_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  count,
    output logic              underflow
);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] wr_value;
    logic [CNT_W-1:0] stepped;
    logic [PS_W-1:0]  ps_q;
    logic             cnt_tick;
    logic             any_wr;

    assign cnt_tick = step_en && (ps_q == '0);
    assign any_wr   = |byte_wr;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign wr_value[b*BYTE_W +: BYTE_W] =
            byte_wr[b] ? wdata : count_q[b*BYTE_W +: BYTE_W];
    end

    assign stepped   = (count_q == '0) ? reload_q : count_q - 1'b1;
    assign underflow = cnt_tick && !any_wr && (count_q == '0);
    assign count     = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            reload_q <= '0;
            ps_q     <= '0;
        end else begin
            if (step_en)
                ps_q <= (ps_q == '0) ? ps_reload : ps_q - 1'b1;
            if (any_wr) begin
                count_q  <= wr_value;
                reload_q <= wr_value;
            end else if (cnt_tick) begin
                count_q <= stepped;
            end
        end
    end

    // R1: any byte write leaves reload equal to the new count
    a_r1_reload_copy: assert property (@(posedge clk) disable iff (rst)
        any_wr |=> (reload_q == count_q));

    // R2: no step and no write keeps count and prescaler frozen
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !any_wr) |=> ($stable(count_q) && $stable(ps_q)));

    // R3: a nonzero count steps down by exactly one
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && !any_wr && (count_q != '0)) |=> (count_q == $past(count_q) - 1'b1));

    // R5: wrap from zero refills from the reload register
    a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
        underflow |=> (count_q == reload_q));

endmodule

// File: rtl/prt_irq.sv
module prt_irq
    import prt_pkg::*;
(
    input  ictl_t      ictl,
    input  logic       cpu_ie,
    input  logic [2:0] cpu_prio,
    output logic       pending
);

    logic outranks;

    assign outranks = ictl.level > cpu_prio;
    assign pending  = cpu_ie && ictl.req && outranks;

endmodule

// File: rtl/prt_timer.sv
module prt_timer
    import prt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int FIX_A  = 8,
    parameter int FIX_B  = 32,
    localparam int NB    = CNT_W / BYTE_W,
    localparam int PS_W  = $clog2(max3(FIX_A, FIX_B, 15) + 1),
    localparam int OFF_RUN  = NB,
    localparam int OFF_MODE = NB + 1,
    localparam int OFF_DIV  = NB + 2,
    localparam int OFF_ICTL = NB + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              tick,
    input  logic              cpu_ie,
    input  logic [2:0]        cpu_prio,
    output logic              irq_pending
);

    logic [BYTE_W-1:0] run_q, mode_q, div_q;
    ictl_t             ictl_q;
    logic [CNT_W-1:0]  count;
    logic [NB-1:0]     byte_wr;
    logic              underflow;
    logic              step_en;
    logic [PS_W-1:0]   ps_reload;
    ps_sel_e           ps_sel;

    for (genvar b = 0; b < NB; b++) begin : g_bwr
        assign byte_wr[b] = bus_wr && (int'(bus_addr) == b);
    end

    assign step_en   = run_q[0] && tick;
    assign ps_sel    = ps_sel_e'(mode_q[7:6]);
    assign ps_reload = PS_W'(ps_pick(ps_sel, div_q[3:0], FIX_A, FIX_B));

    prt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .run_wr  (bus_wr && (int'(bus_addr) == OFF_RUN)),
        .mode_wr (bus_wr && (int'(bus_addr) == OFF_MODE)),
        .div_wr  (bus_wr && (int'(bus_addr) == OFF_DIV)),
        .ictl_wr (bus_wr && (int'(bus_addr) == OFF_ICTL)),
        .wdata   (bus_wdata),
        .req_set (underflow),
        .run_q   (run_q),
        .mode_q  (mode_q),
        .div_q   (div_q),
        .ictl_q  (ictl_q)
    );

    prt_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .ps_reload (ps_reload),
        .byte_wr   (byte_wr),
        .wdata     (bus_wdata),
        .count     (count),
        .underflow (underflow)
    );

    prt_irq u_irq (
        .ictl     (ictl_q),
        .cpu_ie   (cpu_ie),
        .cpu_prio (cpu_prio),
        .pending  (irq_pending)
    );

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NB; b++)
            if (int'(bus_addr) == b) bus_rdata = count[b*BYTE_W +: BYTE_W];
        if (int'(bus_addr) == OFF_RUN)  bus_rdata = run_q;
        if (int'(bus_addr) == OFF_MODE) bus_rdata = mode_q;
        if (int'(bus_addr) == OFF_DIV)  bus_rdata = div_q;
        if (int'(bus_addr) == OFF_ICTL) bus_rdata = ictl_q;
    end

    // R2: with run bit clear the count only moves by bus writes
    a_r2_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run_q[0] && !(|byte_wr)) |=> $stable(count));

    // R7: pending only when the level outranks the CPU priority
    a_r7_rank: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> (ictl_q.level > cpu_prio) && cpu_ie);

    // R7: pending requires a latched request
    a_r7_needs_req: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> ictl_q.req);

endmodule

// File: tb/prt_timer_tb.sv
`timescale 1ns/100ps
module prt_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick = 1'b0;
    logic       cpu_ie = 1'b0;
    logic [2:0] cpu_prio = '0;
    logic       irq_pending;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // model state
    logic [15:0] m_count, m_reload;
    int          m_ps;
    logic [7:0]  m_run, m_mode, m_div, m_ic;

    always #2.5 clk = ~clk;

    prt_timer u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
        .cpu_ie(cpu_ie), .cpu_prio(cpu_prio), .irq_pending(irq_pending)
    );

    function automatic int ps_val();
        case (m_mode[7:6])
            2'b00: return 0;
            2'b01: return 8;
            2'b10: return int'(m_div[3:0]);
            default: return 32;
        endcase
    endfunction

    function automatic logic [7:0] mread(int a);
        case (a)
            0: return m_count[7:0];
            1: return m_count[15:8];
            2: return m_run;
            3: return m_mode;
            4: return m_div;
            5: return m_ic;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit mirq();
        return cpu_ie && m_ic[3] && (m_ic[2:0] > cpu_prio);
    endfunction

    task automatic model_reset();
        m_count = '0; m_reload = '0; m_ps = 0;
        m_run = '0; m_mode = '0; m_div = '0; m_ic = '0;
    endtask

    task automatic model_step(bit wr, int a, logic [7:0] d, bit tk);
        bit cstep = 0;
        bit uf = 0;
        int rel = ps_val();
        if (m_run[0] && tk) begin
            if (m_ps == 0) begin m_ps = rel; cstep = 1; end
            else m_ps = m_ps - 1;
        end
        if (wr && (a == 0 || a == 1)) begin
            if (a == 0) m_count[7:0] = d; else m_count[15:8] = d;
            m_reload = m_count;
        end else if (cstep) begin
            if (m_count == 0) begin m_count = m_reload; uf = 1; end
            else m_count = m_count - 1;
        end
        if (wr && a == 5) m_ic = d;
        else if (uf && m_ic[2:0] != 0) m_ic[3] = 1'b1;
        if (wr && a == 2) m_run = d;
        if (wr && a == 3) m_mode = d;
        if (wr && a == 4) m_div = d;
    endtask

    task automatic cyc(bit wr, int a, logic [7:0] d, bit tk);
        @(negedge clk);
        bus_wr = wr; bus_addr = 3'(a); bus_wdata = d; tick = tk;
        model_step(wr, a, d, tk);
        @(posedge clk);
        #0.5;
        bus_wr = 1'b0; tick = 1'b0;
    endtask

    // reads every offset and the pending output; called in the high phase
    task automatic check_all(string tag);
        for (int a = 0; a < 8; a++) begin
            bus_addr = 3'(a);
            #0.2;
            tests++;
            if (bus_rdata !== mread(a)) begin
                fails++;
                $display("FAIL %s (R8 read map) offset %0d: actual %02h expected %02h",
                         tag, a, bus_rdata, mread(a));
            end
        end
        tests++;
        if (irq_pending !== mirq()) begin
            fails++;
            $display("FAIL %s (R7 pending): actual %0b expected %0b", tag, irq_pending, mirq());
        end
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) begin
            cyc(0, 0, 8'h00, 1);
            check_all(tag);
        end
    endtask

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2.0;
        check_all("R11 reset state");

        // R1: byte writes and reload copy
        cyc(1, 0, 8'h03, 0); check_all("R1 low byte");
        cyc(1, 1, 8'h01, 0); check_all("R1 high byte");
        cyc(1, 1, 8'h00, 0); check_all("R1 high byte clear");

        // R9 / R6: level 5, mode 00, run
        cyc(1, 5, 8'h05, 0); check_all("R9 ictl write");
        cyc(1, 3, 8'h00, 0);
        cyc(1, 2, 8'h01, 0); check_all("R2 run set");
        ticks(4, "R4 mode 00 / R5 R6 underflow");

        cpu_ie = 1'b1; cpu_prio = 3'd4; #0.1; check_all("R7 level above prio");
        cpu_prio = 3'd5; #0.1; check_all("R7 level equal prio");
        cpu_prio = 3'd0; cpu_ie = 1'b0; #0.1; check_all("R7 interrupts disabled");
        cpu_ie = 1'b1;

        cyc(1, 5, 8'h05, 0); check_all("R9 clear request");
        cyc(1, 5, 8'h00, 0);
        ticks(5, "R6 level zero no request");

        cyc(1, 3, 8'h40, 0);
        ticks(22, "R4 R3 mode 01 divide");
        cyc(1, 4, 8'hF3, 0);
        cyc(1, 3, 8'h80, 0);
        ticks(12, "R4 R3 mode 10 field divide");
        cyc(1, 3, 8'hC0, 0);
        ticks(70, "R4 R3 mode 11 divide");

        cyc(1, 2, 8'h00, 0);
        ticks(10, "R2 stopped holds");

        cyc(1, 3, 8'h00, 0);
        cyc(1, 2, 8'h01, 0);
        ticks(40, "R3 settle mode 00");
        cyc(1, 0, 8'h07, 1); check_all("R10 write beats step");
        cyc(1, 6, 8'hAA, 0); check_all("R8 write to spare offset");
        cyc(1, 7, 8'h55, 1); check_all("R8 write to spare offset");

        cyc(1, 0, 8'h00, 0);
        cyc(1, 5, 8'h02, 0);
        cyc(0, 0, 8'h00, 1); check_all("R5 R6 zero reload underflow");
        cyc(1, 5, 8'h02, 1); check_all("R9 write beats underflow");
        cyc(1, 0, 8'h00, 1); check_all("R10 write drops underflow");

        // constrained random phase
        for (int i = 0; i < 3000; i++) begin
            bit wr = ($urandom_range(0, 3) == 0);
            int a = $urandom_range(0, 7);
            logic [7:0] d = 8'($urandom);
            if (a == 1) d = d & 8'h00;
            if (a == 0) d = d & 8'h1F;
            if (a == 2) d = 8'($urandom_range(0, 4) != 0);
            cpu_ie = ($urandom_range(0, 3) != 0);
            cpu_prio = 3'($urandom);
            cyc(wr, a, d, $urandom_range(0, 1) == 1);
            check_all("R1-random R3 R5 R6 R9 mix");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired (all requirements): actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule